// File: doc/BRIEF.md
# Crystal Stop Detector

This block supervises a slow crystal clock from a separate, free-running supervision clock. A counter in the supervision domain counts cycles since the last crystal edge it saw. If the crystal produces no rising edge for a full window of supervision cycles, the counter expires and raises a failure flag. The flag is sticky, so a crystal that stalls briefly and then restarts still leaves the flag set until software clears it.

Crystal edges cross into the supervision domain as a toggle. A flop on the crystal clock flips on every rising edge, a two-stage synchronizer carries that flop over, and an XOR with the previous synchronized value turns each flip into a one-cycle pulse. No edge is lost as long as the crystal runs slower than the supervision clock. The same edge pulses feed a start-up counter, which raises a ready flag once the crystal has produced a fixed number of cycles since the oscillator was enabled.

The supervision clock is an RC source with an accuracy of only about 30 percent. The stall window is therefore set in supervision cycles, not in time, and it must be far longer than the slowest crystal period that is legal.

Top module: `xtal_stop_detector`

## Requirements
- R1: While rst_ni is low, fail_o and ready_o are both 0. This holds at start-up and also when reset is applied in the middle of operation.
- R2: With det_en_i high, a crystal whose rising edges are at most 64 supervision cycles apart never sets fail_o.
- R3: With det_en_i high, fail_o goes to 1 once 64 consecutive supervision cycles pass without a detected crystal edge. This happens when the crystal period is 65 supervision cycles or more, and when the crystal stops. A stopped crystal sets fail_o on the 64th supervision clock after det_en_i rises.
- R4: Once set, fail_o stays at 1 after the crystal starts running again.
- R5: A fail_clr_i pulse sampled high while det_en_i is high clears fail_o in the next cycle. If the stall condition is present in the same cycle, the set wins and fail_o stays at 1.
- R6: While det_en_i is low, fail_clr_i has no effect and fail_o cannot rise. When det_en_i goes high, the stall count starts again from zero.
- R7: With osc_en_i high, ready_o rises on the third supervision clock after the 8192nd crystal rising edge. It then stays high for as long as osc_en_i stays high.
- R8: With osc_en_i low, ready_o is 0 from the next cycle and the edge count is cleared. Crystal edges that occur while osc_en_i is low are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sup_clk_i | input | 1 | Supervision clock (free-running RC) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xtal_clk_i | input | 1 | Crystal clock under supervision |
| det_en_i | input | 1 | Enables the stall detector |
| osc_en_i | input | 1 | Oscillator enable; gates the ready count |
| fail_clr_i | input | 1 | Write-one clear of the failure flag |
| fail_o | output | 1 | Sticky crystal failure flag |
| ready_o | output | 1 | Crystal has run the start-up cycle count |

## Verification
The stall detector is driven with crystal waveforms whose periods lie on both sides of the 64-cycle window: exactly 64 and 65, equal and unequal duty cycles, and very fast periods. These patterns separate an off-by-one in the window from a check that looks at duty cycle instead of edge spacing. A crystal that stops and then restarts shows that the flag is sticky. Clear pulses are applied with the detector disabled and while the stall condition is still present, which shows the clear gating and the rule that set beats clear. The ready count is stepped to 8191 and then to 8192 edges, with edges injected while the oscillator is disabled. This shows an exact threshold and shows that edges outside the enable are ignored.

// File: rtl/xsd_pkg.sv
package xsd_pkg;
  parameter int unsigned XSD_STALL_DEF = 64;
  parameter int unsigned XSD_READY_DEF = 8192;
  parameter int unsigned XSD_SYNC_DEF  = 2;
endpackage

// File: rtl/xsd_edge_sync.sv
module xsd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic sclk_i,
  input  logic rst_ni,
  input  logic xclk_i,
  output logic edge_o
);
  logic              tog_q;
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // toggle in crystal domain: one flip per rising edge
  always_ff @(posedge xclk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= ~tog_q;
  end

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], tog_q};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign edge_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/xsd_stall_timer.sv
module xsd_stall_timer #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic edge_i,
  input  logic clr_i,
  output logic fail_o
);
  localparam int unsigned W = $clog2(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;
  logic         expire;
  logic         fail_q;

  assign expire = en_i && !edge_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || edge_i)   cnt_q <= '0;
    else if (cnt_q != LAST)     cnt_q <= cnt_q + 1'b1;
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              fail_q <= 1'b0;
    else if (expire)          fail_q <= 1'b1;
    else if (clr_i && en_i)   fail_q <= 1'b0;
  end

  assign fail_o = fail_q;
endmodule

// File: rtl/xsd_ready_count.sv
module xsd_ready_count #(
  parameter int unsigned TARGET = 8192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic edge_i,
  output logic ready_o
);
  localparam int unsigned W = $clog2(TARGET);
  localparam logic [W-1:0] LAST = W'(TARGET - 1);

  logic [W-1:0] cnt_q;
  logic         ready_q;
  logic         step;
  logic         hit;

  assign step = en_i && edge_i && !ready_q;
  assign hit  = step && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (step)   cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ready_q <= 1'b0;
    else if (!en_i)  ready_q <= 1'b0;
    else if (hit)    ready_q <= 1'b1;
  end

  assign ready_o = ready_q;
endmodule

// File: rtl/xtal_stop_detector.sv
module xtal_stop_detector
  import xsd_pkg::*;
#(
  parameter int unsigned STALL_CYCLES = XSD_STALL_DEF,
  parameter int unsigned READY_CYCLES = XSD_READY_DEF,
  parameter int unsigned SYNC_STAGES  = XSD_SYNC_DEF
) (
  input  logic sup_clk_i,
  input  logic rst_ni,
  input  logic xtal_clk_i,
  input  logic det_en_i,
  input  logic osc_en_i,
  input  logic fail_clr_i,
  output logic fail_o,
  output logic ready_o
);
  logic xtal_edge;

  xsd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .sclk_i (sup_clk_i),
    .rst_ni (rst_ni),
    .xclk_i (xtal_clk_i),
    .edge_o (xtal_edge)
  );

  xsd_stall_timer #(.LIMIT(STALL_CYCLES)) u_stall (
    .clk_i  (sup_clk_i),
    .rst_ni (rst_ni),
    .en_i   (det_en_i),
    .edge_i (xtal_edge),
    .clr_i  (fail_clr_i),
    .fail_o (fail_o)
  );

  xsd_ready_count #(.TARGET(READY_CYCLES)) u_ready (
    .clk_i   (sup_clk_i),
    .rst_ni  (rst_ni),
    .en_i    (osc_en_i),
    .edge_i  (xtal_edge),
    .ready_o (ready_o)
  );
endmodule

// File: rtl/xsd_checker.sv
module xsd_checker #(
  parameter int unsigned STALL = 64
) (
  input logic clk_i,
  input logic rst_ni,
  input logic det_en_i,
  input logic osc_en_i,
  input logic fail_clr_i,
  input logic edge_i,
  input logic fail_o,
  input logic ready_o
);
  localparam int unsigned GW = $clog2(STALL) + 1;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   gap_q <= '0;
    else if (!det_en_i || edge_i)  gap_q <= '0;
    else if (gap_q < GW'(STALL))   gap_q <= gap_q + 1'b1;
  end

  p_stall_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> ($past(gap_q) >= GW'(STALL - 1)));
  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !fail_clr_i |=> fail_o);
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_clr_i && det_en_i && edge_i |=> !fail_o);
  p_clr_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !det_en_i |=> fail_o);
  p_no_rise_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fail_o && !det_en_i |=> !fail_o);
  p_ready_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && osc_en_i |=> ready_o);
  p_ready_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ($past(edge_i) && $past(osc_en_i)));
  p_ready_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_i |=> !ready_o);
endmodule

bind xtal_stop_detector xsd_checker #(.STALL(STALL_CYCLES)) u_chk (
  .clk_i      (sup_clk_i),
  .rst_ni     (rst_ni),
  .det_en_i   (det_en_i),
  .osc_en_i   (osc_en_i),
  .fail_clr_i (fail_clr_i),
  .edge_i     (xtal_edge),
  .fail_o     (fail_o),
  .ready_o    (ready_o)
);

// File: tb/xtal_stop_detector_test.sv
`timescale 1ns/1ps
module xtal_stop_detector_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xtal = 1'b0;
  logic det_en = 1'b0;
  logic osc_en = 1'b0;
  logic clr = 1'b0;
  logic fail, ready;
  int   n_run = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  xtal_stop_detector uut (
    .sup_clk_i  (clk),
    .rst_ni     (rst_n),
    .xtal_clk_i (xtal),
    .det_en_i   (det_en),
    .osc_en_i   (osc_en),
    .fail_clr_i (clr),
    .fail_o     (fail),
    .ready_o    (ready)
  );

  typedef struct packed {
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [15:0] n;
    logic        exp_fail;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{8'd2,  8'd2,  16'd30, 1'b0},  // R2 fast crystal
    '{8'd32, 8'd32, 16'd6,  1'b0},  // R2 period 64, boundary
    '{8'd32, 8'd33, 16'd6,  1'b1},  // R3 period 65
    '{8'd1,  8'd3,  16'd20, 1'b0},  // R2 skewed duty
    '{8'd40, 8'd40, 16'd3,  1'b1},  // R3 period 80
    '{8'd10, 8'd54, 16'd5,  1'b0},  // R2 skewed, period 64
    '{8'd33, 8'd33, 16'd4,  1'b1}   // R3 period 66
  };

  task automatic check(input logic act, input logic exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int hi, input int lo, input int n);
    for (int i = 0; i < n; i++) begin
      xtal = 1'b1; cyc(hi);
      xtal = 1'b0; cyc(lo);
    end
  endtask

  // disable, then enable with a clear so the stall count starts at zero
  task automatic restart_det();
    det_en = 1'b0; cyc(2);
    det_en = 1'b1; clr = 1'b1; cyc(1);
    clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    check(fail, 1'b0, "R1 reset fail");
    check(ready, 1'b0, "R1 reset ready");
    rst_n = 1'b1;
    cyc(2);

    for (int v = 0; v < NV; v++) begin
      restart_det();
      pulses(int'(VEC[v].hi), int'(VEC[v].lo), int'(VEC[v].n));
      check(fail, VEC[v].exp_fail, VEC[v].exp_fail ? "R3 vector" : "R2 vector");
    end

    // permanent stop from enable
    restart_det();
    cyc(60);
    check(fail, 1'b0, "R3 stop before window");
    cyc(6);
    check(fail, 1'b1, "R3 stop after window");

    // set wins over clear while stalled
    clr = 1'b1; cyc(1); clr = 1'b0;
    check(fail, 1'b1, "R5 set beats clear");

    // sticky after restart
    pulses(2, 2, 5);
    check(fail, 1'b1, "R4 sticky after restart");

    // clear ignored while disabled
    det_en = 1'b0; cyc(1);
    clr = 1'b1; cyc(1); clr = 1'b0;
    cyc(1);
    check(fail, 1'b1, "R6 clear ignored when disabled");

    // clear while enabled with crystal running
    det_en = 1'b1;
    xtal = 1'b1; cyc(2);
    clr = 1'b1; cyc(1); clr = 1'b0;
    xtal = 1'b0; cyc(2);
    pulses(2, 2, 3);
    check(fail, 1'b0, "R5 clear");

    // no rise while disabled, count restarts on enable
    det_en = 1'b0;
    cyc(100);
    check(fail, 1'b0, "R6 no rise when disabled");
    det_en = 1'b1;
    cyc(60);
    check(fail, 1'b0, "R6 count restarts at enable");
    cyc(6);
    check(fail, 1'b1, "R6 expiry after re-enable");
    det_en = 1'b0;

    // ready count: edges while disabled are not counted
    osc_en = 1'b0;
    pulses(2, 2, 5);
    check(ready, 1'b0, "R8 no ready while disabled");
    osc_en = 1'b1; cyc(1);
    pulses(2, 2, 8191);
    cyc(2);
    check(ready, 1'b0, "R7 ready after 8191 edges");
    xtal = 1'b1; cyc(3);
    check(ready, 1'b1, "R7 ready at 8192nd edge");
    xtal = 1'b0; cyc(1);
    pulses(2, 2, 10);
    check(ready, 1'b1, "R7 ready holds");
    osc_en = 1'b0; cyc(1);
    check(ready, 1'b0, "R8 ready drops");
    osc_en = 1'b1; cyc(1);
    pulses(2, 2, 1);
    check(ready, 1'b0, "R8 counter cleared");

    // mid-run reset
    det_en = 1'b1; cyc(70);
    check(fail, 1'b1, "R3 fail before reset");
    rst_n = 1'b0; cyc(1);
    check(fail, 1'b0, "R1 reset clears fail");
    check(ready, 1'b0, "R1 reset clears ready");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule